// File: doc/BRIEF.md
# Privilege Mode and Address Window Guard

This block sits beside a processor core's data port and decides, in the same cycle, whether each data access may proceed. It holds a one-bit privilege mode and two window registers: a base (the lowest legal address) and a limit (the number of legal addresses starting at the base). In supervisor mode every access is granted and no check is made. In user mode only addresses inside the window are granted. Any other access is blocked and raises a protection trap pulse with a cause code.

Only supervisor code may load the window registers. A load attempted from user mode changes nothing and raises its own trap cause. An external interrupt or fault, or any trap, puts the block back into supervisor mode at the next clock edge. The only way into user mode is an explicit enter-user command issued from supervisor mode.

Top module: `priv_guard`

## Requirements
- R1: After reset the mode output is 0 (supervisor), and both base and limit are zero, so the first user-mode access at any address traps.
- R2: While the mode is 0, every valid access is granted, no trap is raised, and the mode stays 0.
- R3: While the mode is 1 (user), a valid access at address A is granted exactly when base <= A < base + limit. Otherwise grant is low and the trap pulses in the same cycle with cause 2'b01 for a read or 2'b10 for a write.
- R4: The window end base + limit is formed one bit wider than the address, so a window that runs past the top address does not wrap, and addresses up to the top remain legal.
- R5: An interrupt/fault event input forces the mode to 0 at the next clock edge. This takes precedence over a simultaneous enter-user command.
- R6: Any trap forces the mode to 0 at the next clock edge.
- R7: The enter-user command moves the mode from 0 to 1 at the next clock edge. The mode never goes from 0 to 1 in any other way.
- R8: A load in supervisor mode writes the selected register (select 0 = base, 1 = limit) at the next clock edge, and the new window governs later user accesses.
- R9: A load in user mode leaves both registers unchanged and traps with cause 2'b11. This cause takes precedence over an out-of-window cause in the same cycle.
- R10: Grant is never high in a cycle in which the trap is high. The cause is 2'b00 whenever the trap is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Data access request valid |
| acc_write | input | 1 | Access is a write (1) or read (0) |
| acc_addr | input | ADDR_W | Access address |
| ld_valid | input | 1 | Window register load request |
| ld_sel | input | 1 | Load target: 0 base, 1 limit |
| ld_data | input | ADDR_W | Value to load |
| evt_irq | input | 1 | Interrupt or fault event |
| ret_user | input | 1 | Enter-user-mode command |
| mode_o | output | 1 | Current mode: 0 supervisor, 1 user |
| grant_o | output | 1 | Access granted this cycle |
| trap_o | output | 1 | Protection trap pulse |
| trap_cause_o | output | 2 | Trap cause code |

## Verification
A corrupted base or limit register shows up at the very next user-mode access near a window edge. The grant flips and a trap with an out-of-window cause appears in the same cycle, so each access is swept right after the registers are loaded. A wrong mode bit is seen one edge after the event that should have set it: a trap, an interrupt or an enter-user command. It shows either as a trap in a cycle that should be unchecked, or as a grant where a trap was due. A user-mode load that wrongly lands is revealed by probing the addresses just inside and just outside both edges of the old window.

// File: rtl/priv_guard_pkg.sv
package priv_guard_pkg;

  typedef enum logic {
    MODE_SUP = 1'b0,
    MODE_USR = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_RD_OOB = 2'b01,
    CAUSE_WR_OOB = 2'b10,
    CAUSE_PRIV   = 2'b11
  } cause_e;

  localparam int unsigned WIN_REGS  = 2;
  localparam int unsigned SEL_BASE  = 0;
  localparam int unsigned SEL_LIMIT = 1;

endpackage

// File: rtl/pg_rst_sync.sv
module pg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pg_window_regs.sv
module pg_window_regs
  import priv_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] limit_o
);
  logic [WIN_REGS-1:0][ADDR_W-1:0] regs_w;

  for (genvar g = 0; g < WIN_REGS; g++) begin : g_reg
    logic              hit_en;
    logic [ADDR_W-1:0] val_q;

    always_comb begin
      hit_en = wr_en && (int'(wr_sel) == g);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= '0;
      else if (hit_en) val_q <= wr_data;
    end

    assign regs_w[g] = val_q;
  end

  assign base_o  = regs_w[SEL_BASE];
  assign limit_o = regs_w[SEL_LIMIT];
endmodule

// File: rtl/pg_window_cmp.sv
module pg_window_cmp #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic              inside_o
);
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] addr_ext;
  logic [EXT_W-1:0] base_ext;
  logic [EXT_W-1:0] end_ext;

  always_comb begin
    addr_ext = {1'b0, addr};
    base_ext = {1'b0, base};
    end_ext  = base_ext + {1'b0, limit};
    inside_o = (addr_ext >= base_ext) && (addr_ext < end_ext);
  end
endmodule

// File: rtl/pg_mode_fsm.sv
module pg_mode_fsm
  import priv_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  force_sup,
  input  logic  enter_user,
  output mode_e mode_o
);
  mode_e mode_q;
  mode_e mode_nxt;
  logic  mode_en;

  always_comb begin
    mode_en  = force_sup || (enter_user && (mode_q == MODE_SUP));
    mode_nxt = force_sup ? MODE_SUP : MODE_USR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_SUP;
    else if (mode_en) mode_q <= mode_nxt;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/priv_guard.sv
module priv_guard
  import priv_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              ld_valid,
  input  logic              ld_sel,
  input  logic [ADDR_W-1:0] ld_data,
  input  logic              evt_irq,
  input  logic              ret_user,
  output logic              mode_o,
  output logic              grant_o,
  output logic              trap_o,
  output logic [1:0]        trap_cause_o
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] limit_w;
  logic              inside_w;
  mode_e             mode_w;
  logic              in_user;
  logic              priv_viol;
  logic              oob_viol;
  logic              trap_w;
  logic              reg_wr_en;
  cause_e            cause_w;

  pg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pg_window_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr_en),
    .wr_sel  (ld_sel),
    .wr_data (ld_data),
    .base_o  (base_w),
    .limit_o (limit_w)
  );

  pg_window_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .addr     (acc_addr),
    .base     (base_w),
    .limit    (limit_w),
    .inside_o (inside_w)
  );

  pg_mode_fsm u_mode (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .force_sup  (evt_irq || trap_w),
    .enter_user (ret_user),
    .mode_o     (mode_w)
  );

  always_comb begin
    in_user   = (mode_w == MODE_USR);
    priv_viol = in_user && ld_valid;
    oob_viol  = in_user && acc_valid && !inside_w;
    trap_w    = priv_viol || oob_viol;
    reg_wr_en = ld_valid && !in_user;
    if (priv_viol)     cause_w = CAUSE_PRIV;
    else if (oob_viol) cause_w = acc_write ? CAUSE_WR_OOB : CAUSE_RD_OOB;
    else               cause_w = CAUSE_NONE;
  end

  assign mode_o       = mode_w;
  assign grant_o      = acc_valid && !trap_w && (!in_user || inside_w);
  assign trap_o       = trap_w;
  assign trap_cause_o = cause_w;
endmodule

// File: rtl/priv_guard_chk.sv
module priv_guard_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              ld_valid,
  input logic              ld_sel,
  input logic [ADDR_W-1:0] ld_data,
  input logic              evt_irq,
  input logic              ret_user,
  input logic              mode,
  input logic              grant,
  input logic              trap,
  input logic [1:0]        cause,
  input logic [ADDR_W-1:0] base,
  input logic [ADDR_W-1:0] limit
);
  // R2
  sup_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !mode) |-> (grant && !trap));

  // R5
  irq_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_irq |=> !mode);

  // R6
  trap_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !mode);

  // R7
  user_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode) |-> ($past(ret_user) && !$past(evt_irq)));

  // R8
  base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !mode && !ld_sel) |=> (base == $past(ld_data)));

  // R9
  priv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && mode) |=> ($stable(base) && $stable(limit)));

  // R9
  priv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && mode) |-> (trap && cause == 2'b11));

  // R10
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !grant);

  // R10
  cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |-> (cause == 2'b00));
endmodule

bind priv_guard priv_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .acc_valid (acc_valid),
  .ld_valid  (ld_valid),
  .ld_sel    (ld_sel),
  .ld_data   (ld_data),
  .evt_irq   (evt_irq),
  .ret_user  (ret_user),
  .mode      (mode_o),
  .grant     (grant_o),
  .trap      (trap_o),
  .cause     (trap_cause_o),
  .base      (base_w),
  .limit     (limit_w)
);

// File: tb/priv_guard_test.sv
`timescale 1ns/1ps
module priv_guard_test;
  localparam int unsigned AW = 5;
  localparam int TOP = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          acc_valid, acc_write, ld_valid, ld_sel, evt_irq, ret_user;
  logic [AW-1:0] acc_addr, ld_data;
  logic          mode_o, grant_o, trap_o;
  logic [1:0]    trap_cause_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  priv_guard #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_data(ld_data),
    .evt_irq(evt_irq), .ret_user(ret_user), .mode_o(mode_o), .grant_o(grant_o),
    .trap_o(trap_o), .trap_cause_o(trap_cause_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    acc_valid = 0; acc_write = 0; acc_addr = '0; ld_valid = 0; ld_sel = 0;
    ld_data = '0; evt_irq = 0; ret_user = 0;
  endtask

  // supervisor-mode load; next negedge the register holds the value
  task automatic load(input bit sel, input int val);
    @(negedge clk); clr(); ld_valid = 1; ld_sel = sel; ld_data = AW'(val);
    #5 chk("R8", "no trap on supervisor load", trap_o, 0);
    @(negedge clk); clr();
  endtask

  task automatic go_user(string req);
    @(negedge clk); clr(); ret_user = 1;
    @(negedge clk); clr();
    chk(req, "mode after enter-user", mode_o, 1);
  endtask

  task automatic user_access(string req, input int a, input bit w, input int b, input int l);
    bit in;
    in = (a >= b) && (a < b + l);
    if (mode_o !== 1'b1) go_user("R7");
    @(negedge clk); clr(); acc_valid = 1; acc_write = w; acc_addr = AW'(a);
    #5;
    chk(req, "grant", grant_o, in);
    chk(req, "trap", trap_o, !in);
    chk(req, "cause", trap_cause_o, in ? 0 : (w ? 2 : 1));
    @(negedge clk); clr();
    chk("R6", "mode after access", mode_o, in ? 1 : 0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    clr();
    rst_n = 0;
    #45;
    chk("R1", "mode in reset", mode_o, 0);
    chk("R1", "trap in reset", trap_o, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", "mode after reset", mode_o, 0);
    // empty window from reset: everything traps
    user_access("R1", 0, 0, 0, 0);
    user_access("R1", TOP, 1, 0, 0);

    // R2: supervisor mode grants all addresses
    load(0, 8); load(1, 4);
    for (int a = 0; a <= TOP; a++) begin
      @(negedge clk); clr(); acc_valid = 1; acc_write = a[0]; acc_addr = AW'(a);
      #5;
      chk("R2", "grant in supervisor", grant_o, 1);
      chk("R2", "trap in supervisor", trap_o, 0);
    end
    @(negedge clk); clr();
    chk("R2", "mode stays supervisor", mode_o, 0);

    // R3 / R4 / R8: sweep windows and all addresses
    for (int b = 0; b <= TOP; b += 5) begin
      for (int l = 0; l <= TOP; l++) begin
        if (mode_o !== 1'b0) begin @(negedge clk); clr(); evt_irq = 1; @(negedge clk); clr(); end
        load(0, b); load(1, l);
        for (int a = 0; a <= TOP; a++)
          user_access((b + l > TOP + 1) ? "R4" : "R3", a, a[1], b, l);
      end
    end

    // R4: window ending past the top address
    @(negedge clk); clr(); evt_irq = 1; @(negedge clk); clr();
    load(0, 28); load(1, 31);
    user_access("R4", 31, 0, 28, 31);
    user_access("R4", 27, 1, 28, 31);
    user_access("R8", 28, 0, 28, 31);

    // R9: user-mode load rejected, with precedence over out-of-window
    @(negedge clk); clr(); evt_irq = 1; @(negedge clk); clr();
    load(0, 8); load(1, 4);
    go_user("R7");
    @(negedge clk); clr(); ld_valid = 1; ld_sel = 0; ld_data = 0;
    acc_valid = 1; acc_addr = AW'(9);
    #5;
    chk("R9", "trap on user load", trap_o, 1);
    chk("R9", "cause on user load", trap_cause_o, 3);
    chk("R10", "no grant with trap", grant_o, 0);
    @(negedge clk); clr();
    chk("R9", "mode after user load", mode_o, 0);
    go_user("R7");
    @(negedge clk); clr(); ld_valid = 1; ld_sel = 1; ld_data = AW'(31);
    acc_valid = 1; acc_write = 1; acc_addr = AW'(30);
    #5;
    chk("R9", "priv cause wins over oob", trap_o ? trap_cause_o : 0, 3);
    @(negedge clk); clr();
    user_access("R9", 7, 0, 8, 4);
    user_access("R9", 8, 0, 8, 4);
    user_access("R9", 11, 1, 8, 4);
    user_access("R9", 12, 1, 8, 4);

    // R5: interrupt forces supervisor; wins over enter-user
    go_user("R7");
    @(negedge clk); clr(); evt_irq = 1; acc_valid = 1; acc_addr = AW'(9);
    #5 chk("R5", "grant in window during irq", grant_o, 1);
    chk("R10", "cause idle without trap", trap_cause_o, 0);
    @(negedge clk); clr();
    chk("R5", "mode after irq", mode_o, 0);
    @(negedge clk); clr(); evt_irq = 1; ret_user = 1;
    @(negedge clk); clr();
    chk("R5", "irq beats enter-user", mode_o, 0);

    // R7: no entry to user without the command
    @(negedge clk); clr(); acc_valid = 1; acc_addr = AW'(3);
    @(negedge clk); clr();
    chk("R7", "mode stays supervisor", mode_o, 0);
    go_user("R7");
    @(negedge clk); clr(); ret_user = 1;
    @(negedge clk); clr();
    chk("R7", "enter-user in user mode", mode_o, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule